// File: doc/BRIEF.md
# SDRAM Bank Precharge Tracker

This block watches the command strobes that a memory controller sends to a four-bank SDRAM and keeps a live picture of which banks hold an open row. For every bank it also states whether a precharge may be issued on the next clock edge. That permission follows the read or write burst most recently started in the bank. After a read, the row may be closed a CAS-latency-dependent number of clocks before the last data word leaves the device. After a write, the row may be closed only once the write-recovery time has elapsed after the last data word went in.

When a read or write is issued with the auto-precharge bit set, the block closes the bank by itself on the first edge at which an explicit precharge would have been legal. It flags that internal event for one cycle. A controller uses the flags to schedule precharges and activates without breaking bank timing. Burst length and write recovery are parameters. CAS latency is a run-time input.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A command is decoded from the three active-low strobes, written as the bits (ras_n, cas_n, we_n). 011 is activate, 101 is read, 100 is write and 010 is precharge. Every other pattern, including 111, 110 and 000, changes no bank state.
- R2: An activate sets the open flag of the bank whose index is given in binary on `bank_addr`. No other bank flag changes.
- R3: A precharge with `a10` low clears the open flag of the bank selected by `bank_addr`. Every other bank keeps its open flag.
- R4: A precharge with `a10` high clears the open flag of all four banks, whatever the value of `bank_addr`.
- R5: A precharge to a bank that is already closed has no effect. All open flags and all precharge-allowed flags stay as they were.
- R6: The read data for a read issued at edge t starts at edge t+CL and ends at edge t+CL+BL-1. CL is 3 when `cas_lat3` is high and 2 otherwise. The bank's `pre_ok` is low until a precharge at the next edge would fall CL-1 clocks before that last data, so it goes high in the cycle before that edge.
- R7: For a write at edge t, the last data is taken at edge t+BL-1. `pre_ok` of that bank stays low until a precharge at the next edge would come TWR clocks after the last data.
- R8: A read or write with `a10` high closes its bank at the first edge at which `pre_ok` allows a precharge. In the cycle after that edge, `auto_pre_done` is high for that bank for exactly one cycle.
- R9: If an explicit precharge addresses a bank at the same edge at which its pending auto-precharge would complete, the bank closes and no `auto_pre_done` pulse is produced.
- R10: An auto-precharge completing in one bank does not block an explicit command to another bank at the same edge. Both take effect.
- R11: While reset is low, and right after it, every bank is closed, every `pre_ok` is high and no `auto_pre_done` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_addr | input | 2 | Target bank index |
| a10 | input | 1 | All-bank select for precharge; auto-precharge request for read/write |
| cas_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| bank_open | output | 4 | Per-bank open-row flag |
| pre_ok | output | 4 | Per-bank flag: a precharge at the next edge is legal |
| auto_pre_done | output | 4 | One-cycle pulse when a bank closes through auto-precharge |

## Verification
An auto-precharge can complete on the same edge at which the controller applies an explicit command. The bench provokes this by computing, from the burst length and CAS latency, the edge at which a pending auto-precharge matures, and placing either a precharge to the same bank or an activate to a different bank exactly on that edge. In the first case it judges the outcome by checking that the bank is closed and that the event vector stays zero. In the second case it expects the event pulse for the first bank alongside a newly opened second bank.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE
  } cmd_e;

  // Offset, in clocks after the read command, of the final data word.
  function automatic int unsigned rd_last_beat(input int unsigned cl, input int unsigned bl);
    return cl + bl - 1;
  endfunction

  // Precharge may lead the final read word by this many clocks.
  function automatic int unsigned rd_pre_lead(input int unsigned cl);
    return cl - 1;
  endfunction

  // Edges from a read command to the first edge a precharge is legal.
  function automatic int unsigned rd_gap(input int unsigned cl, input int unsigned bl);
    return rd_last_beat(cl, bl) - rd_pre_lead(cl);
  endfunction

  // Edges from a write command to the first edge a precharge is legal.
  function automatic int unsigned wr_gap(input int unsigned bl, input int unsigned twr);
    return (bl - 1) + twr;
  endfunction

  // Decode the three active-low strobes.
  function automatic cmd_e decode_strobes(input logic ras_n, input logic cas_n, input logic we_n);
    cmd_e c;
    unique case ({ras_n, cas_n, we_n})
      3'b011:  c = CMD_ACT;
      3'b101:  c = CMD_RD;
      3'b100:  c = CMD_WR;
      3'b010:  c = CMD_PRE;
      default: c = CMD_NOP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      bank_addr,
  input  logic                 a10,
  output cmd_e                 cmd,
  output logic [NUM_BANKS-1:0] target,
  output logic                 auto_req
);

  logic all_banks;

  assign cmd       = decode_strobes(ras_n, cas_n, we_n);
  assign all_banks = (cmd == CMD_PRE) && a10;
  assign auto_req  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && a10;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign target[i] = (cmd != CMD_NOP) &&
                       (all_banks || (bank_addr == BA_W'(i)));
  end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
  import sdram_trk_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  cmd_e             cmd,
  input  logic             auto_req,
  input  logic [CNT_W-1:0] load_rd,
  input  logic [CNT_W-1:0] load_wr,
  output logic             is_open,
  output logic             pre_ok,
  output logic             auto_done
);

  logic [CNT_W-1:0] hold_cnt;
  logic             pend;
  logic             auto_fire;
  logic             pre_hit;

  assign auto_fire = pend && (hold_cnt == '0);
  assign pre_hit   = hit && (cmd == CMD_PRE);
  assign pre_ok    = (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open   <= 1'b0;
      pend      <= 1'b0;
      hold_cnt  <= '0;
      auto_done <= 1'b0;
    end else begin
      auto_done <= auto_fire && !pre_hit;
      if (hold_cnt != '0) hold_cnt <= hold_cnt - CNT_W'(1);
      // Internal close is applied first; an explicit command may override.
      if (auto_fire) begin
        is_open <= 1'b0;
        pend    <= 1'b0;
      end
      if (hit) begin
        unique case (cmd)
          CMD_ACT: is_open <= 1'b1;
          CMD_RD: begin
            hold_cnt <= load_rd;
            pend     <= auto_req;
          end
          CMD_WR: begin
            hold_cnt <= load_wr;
            pend     <= auto_req;
          end
          CMD_PRE: begin
            is_open <= 1'b0;
            pend    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd == CMD_ACT) |=> is_open);

  // R3
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_hit |=> (!is_open && !pend));

  // R6
  rd_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd == CMD_RD && load_rd != '0) |=> !pre_ok);

  // R8
  auto_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_done |-> !is_open);

  // R8
  auto_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_done |-> $past(pend));

  // R9
  pre_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_hit |=> !auto_done);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int TWR       = 2,
  localparam int BA_W  = $clog2(NUM_BANKS),
  localparam int CNT_W = $clog2(BURST_LEN + TWR + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      bank_addr,
  input  logic                 a10,
  input  logic                 cas_lat3,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic [NUM_BANKS-1:0] auto_pre_done
);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] target;
  logic                 auto_req;
  logic [CNT_W-1:0]     load_rd;
  logic [CNT_W-1:0]     load_wr;
  int unsigned          cl_val;

  sdram_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .bank_addr(bank_addr),
    .a10      (a10),
    .cmd      (cmd),
    .target   (target),
    .auto_req (auto_req)
  );

  // The counter is loaded with the gap less one so that pre_ok rises
  // in the cycle before the first legal precharge edge.
  assign cl_val  = cas_lat3 ? 32'd3 : 32'd2;
  assign load_rd = CNT_W'(rd_gap(cl_val, BURST_LEN) - 1);
  assign load_wr = CNT_W'(wr_gap(BURST_LEN, TWR) - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_slot #(.CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (target[b]),
      .cmd      (cmd),
      .auto_req (auto_req),
      .load_rd  (load_rd),
      .load_wr  (load_wr),
      .is_open  (bank_open[b]),
      .pre_ok   (pre_ok[b]),
      .auto_done(auto_pre_done[b])
    );
  end

  // R1
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP && !(cmd == CMD_PRE && a10)) |-> ($countones(target) == 1));

  // R4
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && a10) |=> (bank_open == '0));

  // R1
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP && auto_pre_done == '0 && $past(rst_n)) |=> $stable(bank_open) || (auto_pre_done != '0));

endmodule

// File: tb/sdram_bank_tracker_bench.sv
module sdram_bank_tracker_bench;

  localparam int NB  = 4;
  localparam int BL  = 4;
  localparam int TWR = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          ras_n, cas_n, we_n;
  logic [1:0]    bank_addr;
  logic          a10;
  logic          cas_lat3;
  logic [NB-1:0] bank_open, pre_ok, auto_pre_done;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  sdram_bank_tracker u_sdram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank_addr(bank_addr), .a10(a10), .cas_lat3(cas_lat3),
    .bank_open(bank_open), .pre_ok(pre_ok), .auto_pre_done(auto_pre_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Sets a command at the next falling edge; it registers at the rising
  // edge that follows; returns at the falling edge after that.
  task automatic drive(input logic [2:0] rcw, input logic [1:0] b, input logic a);
    @(negedge clk);
    {ras_n, cas_n, we_n} = rcw;
    bank_addr = b;
    a10 = a;
    @(negedge clk);
    {ras_n, cas_n, we_n} = 3'b111;
    a10 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Gap in edges from command to first legal precharge, restated.
  function automatic int exp_gap(input bit is_wr, input int cl);
    int first_out, final_out;
    if (is_wr) return BL + TWR - 1;
    first_out = cl;
    final_out = first_out + BL - 1;
    return final_out - (cl - 1);
  endfunction

  initial begin
    rst_n = 1'b0;
    {ras_n, cas_n, we_n} = 3'b111;
    bank_addr = 2'd0;
    a10 = 1'b0;
    cas_lat3 = 1'b0;
    idle(3);
    // R11
    chk("R11", "open in reset", int'(bank_open), 0);
    chk("R11", "pre_ok in reset", int'(pre_ok), 15);
    rst_n = 1'b1;
    idle(1);
    chk("R11", "open after reset", int'(bank_open), 0);
    chk("R11", "pre_ok after reset", int'(pre_ok), 15);
    chk("R11", "auto after reset", int'(auto_pre_done), 0);

    // R1: undecoded patterns change nothing
    drive(3'b110, 2'd1, 1'b0);
    chk("R1", "pattern 110", int'(bank_open), 0);
    drive(3'b000, 2'd2, 1'b0);
    chk("R1", "pattern 000", int'(bank_open), 0);
    drive(3'b011, 2'd0, 1'b0);
    drive(3'b001, 2'd0, 1'b0);
    chk("R1", "pattern 001 keeps bank0 open", int'(bank_open), 1);
    drive(3'b010, 2'd0, 1'b0);

    // R2: activate each bank
    for (int b = 0; b < NB; b++) begin
      drive(3'b011, 2'(b), 1'b0);
      chk("R2", "activate accumulates", int'(bank_open), (1 << (b + 1)) - 1);
    end
    // R3: close one at a time
    for (int b = 0; b < NB; b++) begin
      drive(3'b010, 2'(b), 1'b0);
      chk("R3", "single precharge", int'(bank_open), 15 & ~((1 << (b + 1)) - 1));
    end
    // R5: precharge a closed bank
    for (int b = 0; b < NB; b++) drive(3'b011, 2'(b), 1'b0);
    drive(3'b010, 2'd2, 1'b0);
    drive(3'b010, 2'd2, 1'b0);
    chk("R5", "repeat precharge open", int'(bank_open), 4'b1011);
    chk("R5", "repeat precharge pre_ok", int'(pre_ok), 15);
    // R4: all banks regardless of address
    drive(3'b010, 2'd1, 1'b1);
    chk("R4", "precharge all", int'(bank_open), 0);

    // R6 R7 R8 sweep
    for (int cl = 2; cl <= 3; cl++) begin
      for (int op = 0; op < 2; op++) begin
        for (int au = 0; au < 2; au++) begin
          for (int b = 0; b < NB; b++) begin
            int d;
            string rq;
            cas_lat3 = (cl == 3);
            d = exp_gap(op == 1, cl);
            rq = (au == 1) ? "R8" : ((op == 1) ? "R7" : "R6");
            drive(3'b011, 2'(b), 1'b0);
            drive(op == 1 ? 3'b100 : 3'b101, 2'(b), au == 1);
            for (int j = 0; j <= d + 1; j++) begin
              chk(rq, "pre_ok of target", int'(pre_ok[b]), (j >= d - 1) ? 1 : 0);
              chk(rq, "pre_ok of others", int'(pre_ok | (4'b1 << b)), 15);
              chk(rq, "open of target", int'(bank_open[b]), (au == 1 && j >= d) ? 0 : 1);
              chk(rq, "auto event", int'(auto_pre_done),
                  (au == 1 && j == d) ? (1 << b) : 0);
              @(negedge clk);
            end
            drive(3'b010, 2'd0, 1'b1);
          end
        end
      end
    end

    // R9: explicit precharge on the auto-close edge
    cas_lat3 = 1'b0;
    drive(3'b011, 2'd0, 1'b0);
    drive(3'b101, 2'd0, 1'b1);
    idle(exp_gap(1'b0, 2) - 2);
    drive(3'b010, 2'd0, 1'b0);
    chk("R9", "bank closed", int'(bank_open), 0);
    chk("R9", "no auto event", int'(auto_pre_done), 0);
    idle(1);
    chk("R9", "no late event", int'(auto_pre_done), 0);

    // R10: activate another bank on the auto-close edge
    cas_lat3 = 1'b1;
    drive(3'b011, 2'd0, 1'b0);
    drive(3'b100, 2'd0, 1'b1);
    idle(exp_gap(1'b1, 3) - 2);
    drive(3'b011, 2'd1, 1'b0);
    chk("R10", "auto event bank0", int'(auto_pre_done), 1);
    chk("R10", "bank1 opened bank0 closed", int'(bank_open), 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule